// File: doc/BRIEF.md
# Clock Generator Interrupt and Wake Unit

This block sits beside a clock generator and turns its status events into one interrupt request. It keeps five sticky event flags, each with its own enable bit. Software reads both sets of bits through a small single-cycle register port and clears a flag by writing 1 to it. The flag for the stopped low-speed oscillator also watches two low-speed oscillator control levels. It sets whenever either level drops from 1 to 0, and also when the clock-loss strobe arrives.

A second, separate path merges four wake sources into a cancel signal for the CPU power-state logic. The sources are a peripheral interrupt request, a watchdog NMI, a debug interrupt and a reset request. The cancel signal brings the CPU from HALT or SLEEP back to RUN. It is raised whether or not the CPU goes on to accept the interrupt, so it depends on nothing but the four sources.

The register port has no handshake. A write takes effect at the clock edge on which it is presented. Read data is combinational from the address. The event strobes, the control levels and the wake sources are plain level or pulse inputs, and they are not subject to back-pressure.

Top module: `ckgen_irq_unit`

## Requirements
- R1: After reset, all flags and all enables are 0, and `irq_req` and `cancel_req` are 0.
- R2: Word address 0 reads the flags in bits 4:0, and word address 1 reads the enables in bits 4:0. Bits 15:5 read as 0. Addresses 2 and 3 read as 0, and writes to them change nothing.
- R3: Flag positions are: bit 0 internal oscillator stabilized, bit 1 low-speed oscillator stabilized, bit 2 high-speed oscillator stabilized, bit 3 low-speed oscillator stopped, bit 4 high-speed trimming done. A 1 on `evt_strobe[i]` in a cycle sets flag i at the end of that cycle.
- R4: A write to address 0 with `bus_be[0]`=1 clears each flag whose `bus_wdata` bit is 1. Data bits that are 0 leave their flags unchanged. With `bus_be[0]`=0, the write has no effect.
- R5: When a set event and a write-1 clear hit the same flag in the same cycle, the flag ends up set.
- R6: A write to address 1 with `bus_be[0]`=1 loads the enables from `bus_wdata[4:0]`. With `bus_be[0]`=0, the enables do not change.
- R7: `irq_req` in a cycle equals the OR over all i of (flag i AND enable i) as it stood in the previous cycle.
- R8: Flag 3 sets at the end of any cycle in which `lf_ctl[0]` or `lf_ctl[1]` is 0 after having been 1 in the previous cycle. A control level that stays put or rises does not set the flag, and neither does a level that was already 1 when reset was released.
- R9: `cancel_req` in a cycle equals the OR of `wk_periph`, `wk_wdt_nmi`, `wk_debug` and `wk_reset` from the previous cycle. It does not depend on the flags or the enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 2 | Word address |
| bus_be | input | 2 | Byte selects |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr` |
| evt_strobe | input | 5 | Flag set events, one bit per flag |
| lf_ctl | input | 2 | Low-speed oscillator control levels, watched for a 1-to-0 change |
| wk_periph | input | 1 | Peripheral interrupt request wake source |
| wk_wdt_nmi | input | 1 | Watchdog NMI wake source |
| wk_debug | input | 1 | Debug interrupt wake source |
| wk_reset | input | 1 | Reset request wake source |
| irq_req | output | 1 | Interrupt request to the interrupt controller |
| cancel_req | output | 1 | HALT/SLEEP cancel request |

## Verification
The bench targets a set event and a write-1 clear landing on the same flag in the same cycle. A design that gives the clear priority there loses an event, and the missing flag and `irq_req` show it. It also checks that zero data bits, a cleared `bus_be[0]` and the unused addresses leave state alone; a careless byte-select or address decode would wipe enables or flags. The control-level watcher is driven with rises, steady 1s, single and double falls, and a level already high when reset is released. This exposes detectors that fire on rising edges or on the reset value. Finally, wake sources are toggled with all interrupts masked, which shows up any cancel path that wrongly depends on the interrupt state.

// File: rtl/ckirq_pkg.sv
package ckirq_pkg;
  // flag positions in the status word
  localparam int unsigned FLG_RC_STABLE = 0;
  localparam int unsigned FLG_LF_STABLE = 1;
  localparam int unsigned FLG_HF_STABLE = 2;
  localparam int unsigned FLG_LF_STOP   = 3;
  localparam int unsigned FLG_HF_TRIM   = 4;

  // word addresses of the two registers
  localparam int unsigned REG_STATUS = 0;
  localparam int unsigned REG_ENABLE = 1;

  typedef enum logic [1:0] {
    SEL_STATUS = 2'd0,
    SEL_ENABLE = 2'd1,
    SEL_NONE   = 2'd2
  } reg_sel_e;
endpackage

// File: rtl/ckirq_edge_watch.sv
module ckirq_edge_watch #(
  parameter int unsigned NUM_CTL = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_CTL-1:0] ctl_i,
  output logic               any_fall_o
);
  logic [NUM_CTL-1:0] prev_q;
  logic [NUM_CTL-1:0] fall;

  for (genvar g = 0; g < NUM_CTL; g++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q[g] <= 1'b0;
      else        prev_q[g] <= ctl_i[g];
    end
    assign fall[g] = prev_q[g] & ~ctl_i[g];
  end

  assign any_fall_o = |fall;
endmodule

// File: rtl/ckirq_flag_bank.sv
module ckirq_flag_bank #(
  parameter int unsigned NUM_FLAGS = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_FLAGS-1:0] set_i,
  input  logic                 clr_we_i,
  input  logic                 en_we_i,
  input  logic [NUM_FLAGS-1:0] wbits_i,
  output logic [NUM_FLAGS-1:0] flags_o,
  output logic [NUM_FLAGS-1:0] enables_o,
  output logic                 irq_o
);
  logic [NUM_FLAGS-1:0] flag_q;
  logic [NUM_FLAGS-1:0] en_q;
  logic                 irq_q;

  for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
    logic clr_hit;
    assign clr_hit = clr_we_i & wbits_i[g];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        flag_q[g] <= 1'b0;
      else if (set_i[g]) flag_q[g] <= 1'b1;
      else if (clr_hit)  flag_q[g] <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       en_q <= '0;
    else if (en_we_i) en_q <= wbits_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= |(flag_q & en_q);
  end

  assign flags_o   = flag_q;
  assign enables_o = en_q;
  assign irq_o     = irq_q;
endmodule

// File: rtl/ckirq_wake_merge.sv
module ckirq_wake_merge #(
  parameter int unsigned NUM_SRC = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_i,
  output logic               cancel_o
);
  logic cancel_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cancel_q <= 1'b0;
    else        cancel_q <= |src_i;
  end

  assign cancel_o = cancel_q;
endmodule

// File: rtl/ckgen_irq_unit.sv
module ckgen_irq_unit
  import ckirq_pkg::*;
#(
  parameter int unsigned NUM_FLAGS = 5,
  parameter int unsigned NUM_CTL   = 2,
  parameter int unsigned NUM_WAKE  = 4,
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned ADDR_W    = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_wr,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [DATA_W/8-1:0]  bus_be,
  input  logic [DATA_W-1:0]    bus_wdata,
  output logic [DATA_W-1:0]    bus_rdata,
  input  logic [NUM_FLAGS-1:0] evt_strobe,
  input  logic [NUM_CTL-1:0]   lf_ctl,
  input  logic                 wk_periph,
  input  logic                 wk_wdt_nmi,
  input  logic                 wk_debug,
  input  logic                 wk_reset,
  output logic                 irq_req,
  output logic                 cancel_req
);
  localparam int unsigned PAD_W = DATA_W - NUM_FLAGS;

  reg_sel_e             sel;
  logic                 low_byte;
  logic                 stop_fall;
  logic [NUM_FLAGS-1:0] set_vec;
  logic [NUM_FLAGS-1:0] flag_q;
  logic [NUM_FLAGS-1:0] enable_q;
  logic [NUM_WAKE-1:0]  wake_vec;
  logic                 unused_bus_bits;

  always_comb begin
    if (bus_addr == ADDR_W'(REG_STATUS))      sel = SEL_STATUS;
    else if (bus_addr == ADDR_W'(REG_ENABLE)) sel = SEL_ENABLE;
    else                                      sel = SEL_NONE;
  end

  assign low_byte        = bus_be[0];
  assign unused_bus_bits = ^{bus_wdata[DATA_W-1:NUM_FLAGS], bus_be[DATA_W/8-1:1]};

  ckirq_edge_watch #(.NUM_CTL(NUM_CTL)) u_edge (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctl_i      (lf_ctl),
    .any_fall_o (stop_fall)
  );

  always_comb begin
    set_vec              = evt_strobe;
    set_vec[FLG_LF_STOP] = evt_strobe[FLG_LF_STOP] | stop_fall;
  end

  ckirq_flag_bank #(.NUM_FLAGS(NUM_FLAGS)) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_i     (set_vec),
    .clr_we_i  (bus_wr && low_byte && sel == SEL_STATUS),
    .en_we_i   (bus_wr && low_byte && sel == SEL_ENABLE),
    .wbits_i   (bus_wdata[NUM_FLAGS-1:0]),
    .flags_o   (flag_q),
    .enables_o (enable_q),
    .irq_o     (irq_req)
  );

  assign wake_vec = {wk_reset, wk_debug, wk_wdt_nmi, wk_periph};

  ckirq_wake_merge #(.NUM_SRC(NUM_WAKE)) u_wake (
    .clk      (clk),
    .rst_n    (rst_n),
    .src_i    (wake_vec),
    .cancel_o (cancel_req)
  );

  always_comb begin
    unique case (sel)
      SEL_STATUS: bus_rdata = {{PAD_W{1'b0}}, flag_q};
      SEL_ENABLE: bus_rdata = {{PAD_W{1'b0}}, enable_q};
      default:    bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/ckirq_checker.sv
module ckirq_checker #(
  parameter int unsigned NUM_FLAGS = 5,
  parameter int unsigned NUM_CTL   = 2,
  parameter int unsigned ADDR_W    = 2,
  parameter int unsigned DATA_W    = 16
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 bus_wr,
  input logic [ADDR_W-1:0]    bus_addr,
  input logic [DATA_W/8-1:0]  bus_be,
  input logic [DATA_W-1:0]    bus_wdata,
  input logic [NUM_FLAGS-1:0] evt_strobe,
  input logic [NUM_CTL-1:0]   lf_ctl,
  input logic [3:0]           wake_src,
  input logic [NUM_FLAGS-1:0] flags,
  input logic [NUM_FLAGS-1:0] enables,
  input logic                 irq_req,
  input logic                 cancel_req
);
  logic armed;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_chk
    assert_set_seen_R3: assert property (@(posedge clk) disable iff (!rst_n)
      evt_strobe[g] |=> flags[g]);
    assert_clear_by_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(flags[g]) |-> $past(bus_wr && bus_addr == ADDR_W'(0) && bus_be[0] && bus_wdata[g]));
  end

  assert_enable_by_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    armed && !$stable(enables) |-> $past(bus_wr && bus_addr == ADDR_W'(1) && bus_be[0]));

  assert_irq_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> irq_req == $past(|(flags & enables)));

  for (genvar c = 0; c < NUM_CTL; c++) begin : g_ctl
    assert_ctl_fall_sets_R8: assert property (@(posedge clk) disable iff (!rst_n)
      armed && $fell(lf_ctl[c]) |=> flags[3]);
  end

  assert_cancel_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> cancel_req == $past(|wake_src));
endmodule

bind ckgen_irq_unit ckirq_checker #(
  .NUM_FLAGS(NUM_FLAGS), .NUM_CTL(NUM_CTL), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_wr     (bus_wr),
  .bus_addr   (bus_addr),
  .bus_be     (bus_be),
  .bus_wdata  (bus_wdata),
  .evt_strobe (evt_strobe),
  .lf_ctl     (lf_ctl),
  .wake_src   ({wk_reset, wk_debug, wk_wdt_nmi, wk_periph}),
  .flags      (flag_q),
  .enables    (enable_q),
  .irq_req    (irq_req),
  .cancel_req (cancel_req)
);

// File: tb/ckgen_irq_unit_tb_top.sv
`timescale 1ns/1ps
module ckgen_irq_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [1:0]  bus_addr = '0;
  logic [1:0]  bus_be = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [4:0]  evt_strobe = '0;
  logic [1:0]  lf_ctl = '0;
  logic        wk_periph = 0, wk_wdt_nmi = 0, wk_debug = 0, wk_reset = 0;
  logic        irq_req, cancel_req;

  always #2.5 clk = ~clk;

  ckgen_irq_unit dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_be(bus_be),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_strobe(evt_strobe), .lf_ctl(lf_ctl),
    .wk_periph(wk_periph), .wk_wdt_nmi(wk_wdt_nmi), .wk_debug(wk_debug), .wk_reset(wk_reset),
    .irq_req(irq_req), .cancel_req(cancel_req)
  );

  int    checks = 0;
  int    fails = 0;
  bit    cmp_on = 0;
  bit    done = 0;
  string focus = "R1";

  // behavioural reference state
  logic [4:0] m_flags = '0, m_en = '0;
  logic       m_irq = 0, m_wake = 0;
  logic [1:0] m_prev = '0;

  task automatic check(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s (%s) %s: actual %h expected %h at %0t", req, focus, what, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    logic [4:0] setm, clrm;
    if (!rst_n) begin
      m_flags = '0; m_en = '0; m_irq = 0; m_wake = 0; m_prev = '0;
    end else begin
      m_irq  = |(m_flags & m_en);
      m_wake = wk_periph | wk_wdt_nmi | wk_debug | wk_reset;
      setm = evt_strobe;
      if ((m_prev & ~lf_ctl) != 2'b00) setm[3] = 1'b1;
      clrm = (bus_wr && bus_addr == 2'd0 && bus_be[0]) ? bus_wdata[4:0] : 5'd0;
      m_flags = (m_flags & ~clrm) | setm;
      if (bus_wr && bus_addr == 2'd1 && bus_be[0]) m_en = bus_wdata[4:0];
      m_prev = lf_ctl;
    end
    cmp_on = 1;
    #1;
    if (cmp_on && !done) begin
      check("R7", "irq_req", {15'd0, irq_req}, {15'd0, m_irq});
      check("R9", "cancel_req", {15'd0, cancel_req}, {15'd0, m_wake});
      check("R2", "bus_rdata", bus_rdata,
            (bus_addr == 2'd0) ? {11'd0, m_flags} : (bus_addr == 2'd1) ? {11'd0, m_en} : 16'd0);
    end
  end

  task automatic cyc();
    @(negedge clk);
    bus_wr = 0; evt_strobe = '0;
  endtask
  task automatic wr(input logic [1:0] a, input logic [1:0] be, input logic [15:0] d);
    cyc(); bus_wr = 1; bus_addr = a; bus_be = be; bus_wdata = d;
  endtask
  task automatic rd(input logic [1:0] a);
    cyc(); bus_addr = a;
  endtask
  task automatic evt(input logic [4:0] e);
    cyc(); evt_strobe = e;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    done = 1;
    $display("FAIL watchdog: actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    lf_ctl = 2'b11;                      // high during reset: R8 no false set
    repeat (3) @(negedge clk);
    focus = "R1";
    @(negedge clk); #1;
    check("R1", "irq_req in reset", {15'd0, irq_req}, 16'd0);
    check("R1", "cancel_req in reset", {15'd0, cancel_req}, 16'd0);
    check("R1", "status in reset", bus_rdata, 16'd0);
    rst_n = 1;
    focus = "R1 R8"; for (int i = 0; i < 4; i++) rd(2'(i));
    rd(0); #1; check("R8", "no set from level high at reset", bus_rdata, 16'd0);

    focus = "R3";
    for (int i = 0; i < 5; i++) begin evt(5'(1 << i)); rd(0); end
    #1; check("R3", "all flags", bus_rdata, 16'h001f);

    focus = "R4";
    wr(0, 2'b01, 16'h0000); rd(0);
    wr(0, 2'b10, 16'h001f); rd(0);
    #1; check("R4", "be0 low ignored", bus_rdata, 16'h001f);
    wr(0, 2'b01, 16'hffe4); rd(0);
    #1; check("R4", "clear bit2", bus_rdata, 16'h001b);

    focus = "R6";
    wr(1, 2'b11, 16'hffea); rd(1);
    #1; check("R6", "enable load", bus_rdata, 16'h000a);
    wr(1, 2'b10, 16'h0015); rd(1);
    #1; check("R6", "be0 low ignored", bus_rdata, 16'h000a);

    focus = "R7";
    rd(0); rd(0);
    wr(0, 2'b01, 16'h001f); rd(0); rd(0);
    evt(5'b00100); rd(0); rd(0);          // masked flag: no irq
    evt(5'b01000); rd(0); rd(0);          // enabled flag: irq
    wr(0, 2'b01, 16'h0008); rd(0); rd(0);

    focus = "R5";
    cyc(); bus_wr = 1; bus_addr = 0; bus_be = 2'b01; bus_wdata = 16'h0011; evt_strobe = 5'b10001;
    rd(0); #1; check("R5", "set beats clear", bus_rdata[4:0] & 5'b10001, 16'h0011);
    wr(0, 2'b01, 16'h001f);

    focus = "R2";
    wr(2, 2'b11, 16'hffff); wr(3, 2'b11, 16'hffff); rd(2); rd(3);
    rd(1); #1; check("R2", "enables after stray writes", bus_rdata, 16'h000a);

    focus = "R8";
    cyc(); lf_ctl = 2'b10; rd(0);
    #1; check("R8", "fall on bit0", bus_rdata, 16'h0008);
    wr(0, 2'b01, 16'h0008);
    cyc(); lf_ctl = 2'b11; rd(0); rd(0);
    #1; check("R8", "rise no set", bus_rdata, 16'h0000);
    cyc(); lf_ctl = 2'b00; rd(0);
    #1; check("R8", "double fall", bus_rdata, 16'h0008);
    wr(0, 2'b01, 16'h0008); rd(0); rd(0);
    #1; check("R8", "steady 0 no set", bus_rdata, 16'h0000);

    focus = "R9";
    wr(1, 2'b01, 16'h0000);
    cyc(); wk_periph = 1; cyc(); wk_periph = 0; wk_wdt_nmi = 1;
    cyc(); wk_wdt_nmi = 0; wk_debug = 1; cyc(); wk_debug = 0; wk_reset = 1;
    cyc(); wk_reset = 0; cyc(); cyc();

    focus = "mixed";
    for (int k = 0; k < 600; k++) begin
      @(negedge clk);
      bus_wr = ($urandom % 3) == 0;
      bus_addr = 2'($urandom);
      bus_be = 2'($urandom);
      bus_wdata = 16'($urandom);
      evt_strobe = (($urandom % 4) == 0) ? 5'($urandom) : 5'd0;
      if (($urandom % 5) == 0) lf_ctl = 2'($urandom);
      {wk_reset, wk_debug, wk_wdt_nmi, wk_periph} = (($urandom % 3) == 0) ? 4'($urandom) : 4'd0;
    end
    cyc(); cyc();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule